// File: doc/BRIEF.md
# Event Ring Dequeuer with Cycle-State Tracking

This block drains a fixed-size circular ring of event entries written by a producer. The ring has no redirect entry: every slot, the last one included, carries a real event. The block keeps a dequeue index and an expected ownership bit. An entry belongs to the consumer only while the entry's ownership bit equals that expected value. When the index steps past the final slot it returns to zero, and the expected bit inverts in the same step.

Work happens in passes. A one-cycle interrupt pulse starts a pass from the stored index. The block reads entries through a synchronous memory port and offers each owned entry, in index order, on a valid/ready output. The pass stops at the first entry that is not owned, or when a per-pass event budget runs out. In either case the block then issues a one-cycle register write that tells the producer the new dequeue byte address.

Top module: `evring_dequeuer`

## Requirements
- R1: After synchronous reset the dequeue index is 0 and the expected ownership bit is 1. The event output, the memory read strobe and the dequeue write strobe are all low.
- R2: No memory read takes place until `irq_pulse` is high at a clock edge while the block is idle. Each pass begins at the stored dequeue index.
- R3: An entry is owned only when its bit 96 equals the expected ownership bit. The first entry that is not owned ends the pass and is not emitted.
- R4: Owned entries are emitted in ascending index order, with all 128 bits unchanged.
- R5: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high, `evt_data` holds its value, and neither the index nor the memory port moves.
- R6: Consuming the entry at index ENTRIES-1 sets the index to 0 and inverts the expected ownership bit. That last slot is emitted as an ordinary event.
- R7: Every pass ends with exactly one cycle of `deq_wr_en`, with `deq_wr_addr` equal to `ring_base` plus 16 times the updated index.
- R8: A pass emits at most MAX_PER_PASS events. When it reaches that budget it ends with the dequeue write, and the next pass continues from the following index.
- R9: Each fetch is a single-cycle `mem_rd_en` strobe, and `mem_rd_data` is taken in the next cycle. A pass performs one read per emitted event, plus one more read when it ends on an entry that is not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse | input | 1 | Starts a pass when the block is idle |
| ring_base | input | 64 | Byte address of ring slot 0 |
| mem_rd_en | output | 1 | Ring memory read strobe |
| mem_rd_idx | output | 4 | Slot index to read |
| mem_rd_data | input | 128 | Entry read from the memory, valid the cycle after the strobe |
| evt_valid | output | 1 | An owned entry is on `evt_data` |
| evt_ready | input | 1 | Sink accepts the entry |
| evt_data | output | 128 | The emitted entry |
| deq_wr_en | output | 1 | One-cycle dequeue pointer write |
| deq_wr_addr | output | 64 | Byte address of the new dequeue position |

## Verification
The assertions check on every cycle that a stalled event stays stable and blocks the index, and that the index wraps and the ownership bit flips together. They also check that a rejected entry leads straight to the dequeue write, that every emitted entry carries the expected ownership bit, and that the budget counter stays within its limit. Only the bench scenarios can show the rest: the exact order and content of events across several passes, the correct address values in the dequeue writes, and the budget split of a long run. They also show that a stale entry left over from the previous lap ends a pass once the ownership bit has inverted.

// File: rtl/evring_pkg.sv
package evring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_OFFER,
        ST_PUBLISH
    } pass_state_e;

    localparam int SLOT_BYTES_LOG2 = 4;

    function automatic logic slot_owned(input logic seen_bit, input logic expect_bit);
        return seen_bit == expect_bit;
    endfunction

endpackage

// File: rtl/evring_index_track.sv
module evring_index_track #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             exp_cycle
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            exp_cycle <= 1'b1;
        end else if (advance) begin
            if (idx == LAST_IDX) begin
                idx       <= '0;
                exp_cycle <= ~exp_cycle;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R6: wrap from the last slot resets the index and flips the expected bit
    a_r6_wrap_flip: assert property (@(posedge clk) disable iff (rst)
        (advance && idx == LAST_IDX) |=> (idx == '0 && exp_cycle != $past(exp_cycle)));

    // R6: the expected bit only changes on a wrap
    a_r6_no_stray_flip: assert property (@(posedge clk) disable iff (rst)
        !(advance && idx == LAST_IDX) |=> $stable(exp_cycle));

endmodule

// File: rtl/evring_pass_ctrl.sv
module evring_pass_ctrl
    import evring_pkg::*;
#(
    parameter int MAX_PER_PASS = 8,
    localparam int CNT_W = $clog2(MAX_PER_PASS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic owned,
    input  logic ready,
    output logic fetch,
    output logic capture,
    output logic offer,
    output logic consume,
    output logic publish
);
    localparam logic [CNT_W-1:0] BUDGET = CNT_W'(MAX_PER_PASS);

    pass_state_e      state_q, state_d;
    logic [CNT_W-1:0] used_q, used_d;

    always_comb begin
        state_d = state_q;
        used_d  = used_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FETCH;
                    used_d  = '0;
                end
            end
            ST_FETCH: state_d = ST_CHECK;
            ST_CHECK: state_d = owned ? ST_OFFER : ST_PUBLISH;
            ST_OFFER: begin
                if (ready) begin
                    used_d  = used_q + 1'b1;
                    state_d = (used_q + 1'b1 == BUDGET) ? ST_PUBLISH : ST_FETCH;
                end
            end
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            used_q  <= '0;
        end else begin
            state_q <= state_d;
            used_q  <= used_d;
        end
    end

    assign fetch   = (state_q == ST_FETCH);
    assign capture = (state_q == ST_CHECK) && owned;
    assign offer   = (state_q == ST_OFFER);
    assign consume = offer && ready;
    assign publish = (state_q == ST_PUBLISH);

    // R8: the per-pass event count never exceeds the budget
    a_r8_budget_bound: assert property (@(posedge clk) disable iff (rst)
        used_q <= BUDGET);

    // R5: a stalled offer stays in place
    a_r5_offer_holds: assert property (@(posedge clk) disable iff (rst)
        (offer && !ready) |=> offer);

    // R3: a rejected entry goes straight to the pointer write
    a_r3_reject_ends_pass: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !owned) |=> publish);

endmodule

// File: rtl/evring_deq_addr.sv
module evring_deq_addr
    import evring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) << SLOT_BYTES_LOG2;
        addr   = base + offset;
    end

endmodule

// File: rtl/evring_dequeuer.sv
module evring_dequeuer
    import evring_pkg::*;
#(
    parameter int ENTRIES      = 16,
    parameter int ENTRY_W      = 128,
    parameter int CYCLE_POS    = 96,
    parameter int ADDR_W       = 64,
    parameter int MAX_PER_PASS = 8,
    localparam int IDX_W       = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_pulse,
    input  logic [ADDR_W-1:0]  ring_base,
    output logic               mem_rd_en,
    output logic [IDX_W-1:0]   mem_rd_idx,
    input  logic [ENTRY_W-1:0] mem_rd_data,
    output logic               evt_valid,
    input  logic               evt_ready,
    output logic [ENTRY_W-1:0] evt_data,
    output logic               deq_wr_en,
    output logic [ADDR_W-1:0]  deq_wr_addr
);
    logic             fetch, capture, offer, consume, publish, owned;
    logic [IDX_W-1:0] cur_idx;
    logic             exp_cycle;
    logic [ENTRY_W-1:0] held_q;

    assign owned = slot_owned(mem_rd_data[CYCLE_POS], exp_cycle);

    evring_pass_ctrl #(.MAX_PER_PASS(MAX_PER_PASS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (irq_pulse),
        .owned   (owned),
        .ready   (evt_ready),
        .fetch   (fetch),
        .capture (capture),
        .offer   (offer),
        .consume (consume),
        .publish (publish)
    );

    evring_index_track #(.ENTRIES(ENTRIES)) u_track (
        .clk       (clk),
        .rst       (rst),
        .advance   (consume),
        .idx       (cur_idx),
        .exp_cycle (exp_cycle)
    );

    evring_deq_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base (ring_base),
        .idx  (cur_idx),
        .addr (deq_wr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)          held_q <= '0;
        else if (capture) held_q <= mem_rd_data;
    end

    assign mem_rd_en  = fetch;
    assign mem_rd_idx = cur_idx;
    assign evt_valid  = offer;
    assign evt_data   = held_q;
    assign deq_wr_en  = publish;

    // R5: stalled event keeps its data and the read port stays quiet
    a_r5_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_data) && $stable(mem_rd_idx) && !mem_rd_en));

    // R4: every emitted entry carries the expected ownership bit
    a_r4_emit_owned: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_valid) |-> evt_data[CYCLE_POS] == exp_cycle);

    // R7: the pointer write lasts a single cycle
    a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
        deq_wr_en |=> !deq_wr_en);

    // R9: reading, offering and publishing never overlap
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd_en, evt_valid, deq_wr_en}) <= 1);

endmodule

// File: tb/evring_dequeuer_tb.sv
`timescale 1ns/1ps
module evring_dequeuer_tb_top;
    localparam int N    = 16;
    localparam int MAXP = 8;
    localparam logic [63:0] BASE = 64'h0000_0001_2345_6000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         irq_pulse = 1'b0;
    logic         mem_rd_en;
    logic [3:0]   mem_rd_idx;
    logic [127:0] mem_rd_data;
    logic         evt_valid;
    logic         evt_ready = 1'b1;
    logic [127:0] evt_data;
    logic         deq_wr_en;
    logic [63:0]  deq_wr_addr;

    logic [127:0] ring_mem [N];
    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    evring_dequeuer #(.ENTRIES(N), .MAX_PER_PASS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .ring_base(BASE),
        .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data),
        .deq_wr_en(deq_wr_en), .deq_wr_addr(deq_wr_addr)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= ring_mem[mem_rd_idx];
        if (mem_rd_en) reads <= reads + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_entry(input int tag, input bit cyc);
        logic [127:0] e;
        e = {32'(tag) << 8, ~32'(tag), 32'(tag * 32'h1111), 32'(tag) ^ 32'hC0DE0000};
        e[96] = cyc;
        return e;
    endfunction

    // One pass: pulse, collect events, stall at one position, check the write.
    task automatic run_pass(input int start, input int n_exp, input int stall_at,
                            input bit budget_end, input string req);
        int got = 0;
        int stall_left = 4;
        int r0;
        bit done = 0;
        logic [127:0] last_data = '0;
        @(negedge clk);
        r0 = reads;
        irq_pulse = 1'b1;
        @(negedge clk);
        irq_pulse = 1'b0;
        for (int t = 0; t < 400 && !done; t++) begin
            if (deq_wr_en) begin
                // R7: address reflects updated index
                chk(deq_wr_addr == BASE + 64'((start + n_exp) % N) * 16, {req, " R7 addr"},
                    128'(deq_wr_addr), 128'(BASE + 64'((start + n_exp) % N) * 16));
                chk(got == n_exp, {req, " R4 count"}, 128'(got), 128'(n_exp));
                // R9: one read per event, plus the rejected one
                chk(reads - r0 == n_exp + (budget_end ? 0 : 1), {req, " R9 reads"},
                    128'(reads - r0), 128'(n_exp + (budget_end ? 0 : 1)));
                done = 1;
            end else if (evt_valid) begin
                chk(evt_data == ring_mem[(start + got) % N], {req, " R4 data"},
                    evt_data, ring_mem[(start + got) % N]);
                if (got == stall_at && stall_left > 0) begin
                    if (stall_left < 4)
                        chk(evt_data == last_data && !mem_rd_en, {req, " R5 stall"}, evt_data, last_data);
                    last_data = evt_data;
                    evt_ready = 1'b0;
                    stall_left--;
                end else begin
                    evt_ready = 1'b1;
                    got++;
                end
            end else begin
                evt_ready = 1'b1;
            end
            if (!done) @(negedge clk);
        end
        evt_ready = 1'b1;
        chk(done, {req, " R7 write seen"}, 128'(done), 128'(1));
        @(negedge clk);
        chk(!deq_wr_en, {req, " R7 one cycle"}, 128'(deq_wr_en), 128'(0));
    endtask

    task automatic t_reset_idle();
        int r0;
        chk(!evt_valid && !deq_wr_en && !mem_rd_en, "R1 idle outputs",
            128'({evt_valid, deq_wr_en, mem_rd_en}), 128'(0));
        r0 = reads;
        repeat (10) @(negedge clk);
        chk(reads == r0, "R2 no read without irq", 128'(reads - r0), 128'(0));
    endtask

    task automatic t_empty();
        // R1/R3: zeroed ring, expected bit 1 -> nothing owned, publish index 0
        run_pass(0, 0, -1, 0, "R3 empty");
    endtask

    task automatic t_three();
        for (int i = 0; i < 3; i++) ring_mem[i] = mk_entry(10 + i, 1'b1);
        run_pass(0, 3, -1, 0, "R4 three");
    endtask

    task automatic t_stall();
        ring_mem[3] = mk_entry(20, 1'b1);
        run_pass(3, 1, 0, 0, "R5 stall");
    endtask

    task automatic t_budget();
        for (int i = 4; i < 14; i++) ring_mem[i] = mk_entry(30 + i, 1'b1);
        run_pass(4, MAXP, -1, 1, "R8 first");
        run_pass(12, 2, -1, 0, "R8 rest");
    endtask

    task automatic t_wrap();
        ring_mem[14] = mk_entry(50, 1'b1);
        ring_mem[15] = mk_entry(51, 1'b1);
        ring_mem[0]  = mk_entry(52, 1'b0);
        ring_mem[1]  = mk_entry(53, 1'b0);
        // R6: slot 2 still has bit 1 from the last lap and must stop the pass
        run_pass(14, 4, 2, 0, "R6 wrap");
        ring_mem[2] = mk_entry(54, 1'b0);
        run_pass(2, 1, -1, 0, "R6 after wrap");
    endtask

    initial begin
        for (int i = 0; i < N; i++) ring_mem[i] = '0;
        mem_rd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_idle();
        t_empty();
        t_three();
        t_stall();
        t_budget();
        t_wrap();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule